// File: doc/BRIEF.md
# QAM Byte-to-Symbol Differential Mapper

This block sits in a cable modulator between the byte-wide output of the outer code and interleaver and the constellation mapper. It slices the incoming byte stream into symbol words of m bits, where m is 4, 5, 6, 7 or 8 for 16, 32, 64, 128 or 256-QAM. A symbol may straddle two bytes: at m=6, for instance, three bytes give four symbols. The two top bits of every symbol are then differentially encoded so that a receiver can resolve a constellation rotated by a multiple of 90 degrees. The m-2 lower bits pass unchanged.

The QAM order and the transmission variant (A or C) are run-time inputs. Both are taken only from a byte flagged as the start of a frame. That byte also discards any leftover bits too few to form a symbol and restarts the differential state. The input uses a valid/ready handshake and the output uses a valid/ready handshake. Each output symbol is right-justified in an 8-bit word, and its encoded quadrant pair is also given on its own for the mapper.

The packer has two states. PK_NEED means fewer than m bits are buffered; it leaves on any accepted byte that brings the count to m or more. PK_HAVE means a full symbol is available; it stays while the count remains at m or more and returns to PK_NEED otherwise. The output stage also has two states. OS_EMPTY moves to OS_FULL when a symbol is available. OS_FULL stays loaded while a new symbol replaces the one leaving, or while the output is stalled. It returns to OS_EMPTY when the symbol leaves and no new one is ready.

Top module: `qam_diff_mapper`

## Requirements
- R1: The symbol width m is taken from `qam_sel` on an accepted byte with `in_sof` high. Codes 0, 1, 2, 3 and 4 give m = 4, 5, 6, 7 and 8; codes 5 to 7 give m = 8. After reset, before any frame start, m is 8 and variant A is in use.
- R2: Bits are consumed most significant bit first, byte after byte, with no bit skipped or reused across byte boundaries. Each symbol appears in `sym_out[m-1:0]` with the earliest bit at position m-1, and the bits of `sym_out` above m-1 are zero.
- R3: The symbol's top bits are A (bit m-1) and B (bit m-2), and the previous output pair is (Ip, Qp). If A equals B, the output pair is I=A, Q=B. Otherwise, variant A (`annex_c`=0) gives I=A^Qp, Q=B^Ip, and variant C (`annex_c`=1) gives I=A^Ip, Q=B^Qp. I replaces bit m-1 and Q replaces bit m-2 of `sym_out`, and `quad_i`/`quad_q` carry the same two values.
- R4: The previous pair (Ip, Qp) is 00 for the first symbol after reset and for the first symbol of every frame.
- R5: A frame-start byte discards buffered bits fewer than m. It is accepted only when fewer than m bits are buffered, so every complete symbol of the old frame is delivered first. Back-to-back frames with different widths are repacked correctly.
- R6: `sym_valid` is low after reset. While `sym_valid` is high and `out_ready` is low, `sym_out`, `quad_i` and `quad_q` stay unchanged.
- R7: `in_ready` is high after reset and whenever fewer than m bits are buffered. When m or more bits are buffered, it is high only in a cycle where a symbol moves to the output and the buffer has room, and never for a frame-start byte. With the output stalled and a symbol waiting, `in_ready` is low.
- R8: Changes to `qam_sel` and `annex_c` in the middle of a frame have no effect until the next frame-start byte.
- R9: Every complete symbol is delivered exactly once and in order, with no extra symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Byte starts a frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| qam_sel | input | 3 | QAM order code, taken at frame start |
| annex_c | input | 1 | Variant select (0 = A, 1 = C), taken at frame start |
| sym_out | output | 8 | Encoded symbol, right-justified |
| sym_valid | output | 1 | Symbol valid |
| out_ready | input | 1 | Downstream accepts symbol |
| quad_i | output | 1 | Encoded quadrant bit I |
| quad_q | output | 1 | Encoded quadrant bit Q |

## Verification
The bench compares the output against a bit-serial model across every width and both variants, including symbols that straddle bytes. A packer that indexes bits wrongly at a byte boundary would corrupt the symbol that spans the join. Short frames switch width from one byte to the next, so a design that kept stale residue or failed to restart the quadrant state would misalign the next frame or produce a wrong first quadrant. Changes to the mode inputs inside a frame catch a design that samples them continuously. A forced output stall checks that input is refused and that the held symbol does not move, which a design with an overrunning buffer or an unguarded output register would get wrong.

// File: rtl/qdm_pkg.sv
package qdm_pkg;

    typedef logic [3:0] width_t;

    typedef enum logic [0:0] {
        PK_NEED = 1'b0,
        PK_HAVE = 1'b1
    } pk_state_e;

    typedef enum logic [0:0] {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } os_state_e;

    function automatic width_t width_of(input logic [2:0] code);
        width_t w;
        if (code <= 3'd4)
            w = width_t'(code) + 4'd4;
        else
            w = 4'd8;
        return w;
    endfunction

endpackage

// File: rtl/qdm_packer.sv
module qdm_packer
    import qdm_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter int SYM_W = 8,
    localparam int CNT_W = $clog2(ACC_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [2:0]         qam_sel,
    input  logic               annex_c,
    input  logic               take,
    output logic               in_ready,
    output logic               sym_avail,
    output logic [SYM_W-1:0]   sym_raw,
    output width_t             cur_w,
    output logic               cur_var,
    output logic               frame_clr,
    output logic [CNT_W-1:0]   buf_cnt
);

    pk_state_e          st_q, st_n;
    logic [ACC_W-1:0]   acc_q, acc_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    width_t             w_q, w_n;
    logic               var_q, var_n;
    logic               room;
    logic               accept;
    logic [CNT_W-1:0]   shamt;
    logic [ACC_W-1:0]   shifted;

    assign room = (int'(cnt_q) - int'(w_q) + 8) <= ACC_W;

    always_comb begin
        in_ready  = 1'b0;
        sym_avail = 1'b0;
        shamt     = '0;
        unique case (st_q)
            PK_NEED: begin
                in_ready  = 1'b1;
                sym_avail = 1'b0;
            end
            PK_HAVE: begin
                in_ready  = take && !in_sof && room;
                sym_avail = 1'b1;
                shamt     = cnt_q - CNT_W'(w_q);
            end
        endcase
    end

    assign accept  = in_valid && in_ready;
    assign shifted = acc_q >> shamt;

    for (genvar g = 0; g < SYM_W; g++) begin : g_mask
        assign sym_raw[g] = sym_avail && (g < int'(w_q)) && shifted[g];
    end

    always_comb begin
        acc_n     = acc_q;
        cnt_n     = cnt_q;
        w_n       = w_q;
        var_n     = var_q;
        frame_clr = 1'b0;
        if (accept && in_sof) begin
            acc_n     = ACC_W'(in_data);
            cnt_n     = CNT_W'(8);
            w_n       = width_of(qam_sel);
            var_n     = annex_c;
            frame_clr = 1'b1;
        end else begin
            if (take)
                cnt_n = cnt_q - CNT_W'(w_q);
            if (accept) begin
                acc_n = {acc_q[ACC_W-9:0], in_data};
                cnt_n = cnt_n + CNT_W'(8);
            end
        end
        st_n = (cnt_n >= CNT_W'(w_n)) ? PK_HAVE : PK_NEED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PK_NEED;
            acc_q <= '0;
            cnt_q <= '0;
            w_q   <= 4'd8;
            var_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            acc_q <= acc_n;
            cnt_q <= cnt_n;
            w_q   <= w_n;
            var_q <= var_n;
        end
    end

    assign cur_w   = w_q;
    assign cur_var = var_q;
    assign buf_cnt = cnt_q;

endmodule

// File: rtl/qdm_diffenc.sv
module qdm_diffenc (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic var_c,
    input  logic a,
    input  logic b,
    output logic i_o,
    output logic q_o
);

    logic ip_q, qp_q;

    always_comb begin
        if (a == b) begin
            i_o = a;
            q_o = b;
        end else if (var_c) begin
            i_o = a ^ ip_q;
            q_o = b ^ qp_q;
        end else begin
            i_o = a ^ qp_q;
            q_o = b ^ ip_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q <= 1'b0;
            qp_q <= 1'b0;
        end else if (clr) begin
            ip_q <= 1'b0;
            qp_q <= 1'b0;
        end else if (adv) begin
            ip_q <= i_o;
            qp_q <= q_o;
        end
    end

endmodule

// File: rtl/qam_diff_mapper.sv
module qam_diff_mapper
    import qdm_pkg::*;
#(
    parameter int ACC_W = 16,
    localparam int SYM_W = 8,
    localparam int CNT_W = $clog2(ACC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic             in_ready,
    input  logic [2:0]       qam_sel,
    input  logic             annex_c,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_valid,
    input  logic             out_ready,
    output logic             quad_i,
    output logic             quad_q
);

    os_state_e          os_q, os_n;
    logic               take;
    logic               sym_avail;
    logic [SYM_W-1:0]   sym_raw;
    logic [SYM_W-1:0]   sym_next;
    width_t             buf_w;
    width_t             out_w_q;
    logic               cur_var;
    logic               frame_clr;
    logic [CNT_W-1:0]   buf_cnt;
    logic               top_a, top_b;
    logic               enc_i, enc_q;
    logic [SYM_W-1:0]   sym_q;
    logic               qi_q, qq_q;

    qdm_packer #(.ACC_W(ACC_W), .SYM_W(SYM_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .qam_sel   (qam_sel),
        .annex_c   (annex_c),
        .take      (take),
        .in_ready  (in_ready),
        .sym_avail (sym_avail),
        .sym_raw   (sym_raw),
        .cur_w     (buf_w),
        .cur_var   (cur_var),
        .frame_clr (frame_clr),
        .buf_cnt   (buf_cnt)
    );

    always_comb begin
        top_a = 1'b0;
        top_b = 1'b0;
        for (int k = 0; k < SYM_W; k++) begin
            if (k == int'(buf_w) - 1) top_a = sym_raw[k];
            if (k == int'(buf_w) - 2) top_b = sym_raw[k];
        end
    end

    qdm_diffenc u_diff (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_clr),
        .adv   (take),
        .var_c (cur_var),
        .a     (top_a),
        .b     (top_b),
        .i_o   (enc_i),
        .q_o   (enc_q)
    );

    for (genvar g = 0; g < SYM_W; g++) begin : g_merge
        assign sym_next[g] = (g == int'(buf_w) - 1) ? enc_i :
                             (g == int'(buf_w) - 2) ? enc_q : sym_raw[g];
    end

    always_comb begin
        take = 1'b0;
        os_n = os_q;
        unique case (os_q)
            OS_EMPTY: begin
                take = sym_avail;
                os_n = sym_avail ? OS_FULL : OS_EMPTY;
            end
            OS_FULL: begin
                take = sym_avail && out_ready;
                os_n = (out_ready && !sym_avail) ? OS_EMPTY : OS_FULL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            os_q <= OS_EMPTY;
        else
            os_q <= os_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_q   <= '0;
            qi_q    <= 1'b0;
            qq_q    <= 1'b0;
            out_w_q <= 4'd8;
        end else if (take) begin
            sym_q   <= sym_next;
            qi_q    <= enc_i;
            qq_q    <= enc_q;
            out_w_q <= buf_w;
        end
    end

    assign sym_valid = (os_q == OS_FULL);
    assign sym_out   = sym_q;
    assign quad_i    = qi_q;
    assign quad_q    = qq_q;

endmodule

// File: rtl/qdm_checker.sv
module qdm_checker #(
    parameter int ACC_W = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_ready,
    input logic             sym_valid,
    input logic             out_ready,
    input logic [7:0]       sym_out,
    input logic             quad_i,
    input logic             quad_q,
    input logic [3:0]       out_w,
    input logic [3:0]       buf_w,
    input logic [CNT_W-1:0] buf_cnt
);

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !out_ready |=> sym_valid && $stable(sym_out) && $stable(quad_i) && $stable(quad_q)); // R6

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_out >> out_w) == 8'd0); // R2

    AST_QUAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (quad_i == sym_out[out_w - 4'd1]) && (quad_q == sym_out[out_w - 4'd2])); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(buf_cnt) <= ACC_W); // R7

    AST_SOF_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_sof |-> buf_cnt < CNT_W'(buf_w)); // R5

    AST_READY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt < CNT_W'(buf_w) |-> in_ready); // R7

    AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        buf_w >= 4'd4 && buf_w <= 4'd8); // R1

endmodule

bind qam_diff_mapper qdm_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_ready  (in_ready),
    .sym_valid (sym_valid),
    .out_ready (out_ready),
    .sym_out   (sym_out),
    .quad_i    (quad_i),
    .quad_q    (quad_q),
    .out_w     (out_w_q),
    .buf_w     (buf_w),
    .buf_cnt   (buf_cnt)
);

// File: tb/qam_diff_mapper_test.sv
`timescale 1ns/1ps
module qam_diff_mapper_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_ready;
    logic [2:0] qam_sel = 3'd4;
    logic       annex_c = 1'b0;
    logic [7:0] sym_out;
    logic       sym_valid;
    logic       out_ready = 1'b1;
    logic       quad_i, quad_q;

    always #5 clk = ~clk;

    qam_diff_mapper uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sof(in_sof), .in_ready(in_ready), .qam_sel(qam_sel), .annex_c(annex_c),
        .sym_out(sym_out), .sym_valid(sym_valid), .out_ready(out_ready),
        .quad_i(quad_i), .quad_q(quad_q)
    );

    typedef struct {
        logic [7:0] sym;
        logic       qi;
        logic       qq;
        string      tag;
    } exp_t;

    exp_t  exp_q[$];
    bit    ref_bits[$];
    int    ref_m = 8;
    bit    ref_var = 1'b0;
    bit    ref_ip = 1'b0, ref_qp = 1'b0;
    string cur_tag = "R1";
    int    checks = 0, fails = 0;
    bit    mon_en = 1'b0;
    int    stall_mode = 0;

    function automatic int width_code(input logic [2:0] c);
        return (c <= 3'd4) ? 4 + int'(c) : 8;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void ref_push(input logic [7:0] b, input logic s);
        if (s) begin
            ref_bits.delete();
            ref_m   = width_code(qam_sel);
            ref_var = annex_c;
            ref_ip  = 1'b0;
            ref_qp  = 1'b0;
        end
        for (int k = 7; k >= 0; k--) ref_bits.push_back(b[k]);
        while (ref_bits.size() >= ref_m) begin
            logic [7:0] sv;
            bit a, bb, ni, nq;
            exp_t e;
            sv = 8'h00;
            for (int j = 0; j < ref_m; j++) sv = {sv[6:0], ref_bits.pop_front()};
            a  = sv[ref_m-1];
            bb = sv[ref_m-2];
            if (a == bb) begin
                ni = a; nq = bb;
            end else if (ref_var) begin
                ni = a ^ ref_ip; nq = bb ^ ref_qp;
            end else begin
                ni = a ^ ref_qp; nq = bb ^ ref_ip;
            end
            ref_ip = ni;
            ref_qp = nq;
            sv[ref_m-1] = ni;
            sv[ref_m-2] = nq;
            e.sym = sv; e.qi = ni; e.qq = nq; e.tag = cur_tag;
            exp_q.push_back(e);
        end
    endfunction

    // Called at posedge+1; returns at posedge+1 right after the byte is taken.
    task automatic send(input logic [7:0] b, input logic s);
        in_valid = 1'b1;
        in_data  = b;
        in_sof   = s;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        ref_push(b, s);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    always @(posedge clk) begin
        #1;
        if (stall_mode == 1)
            out_ready = ($urandom % 4) != 0;
        else if (stall_mode == 2)
            out_ready = 1'b0;
        else
            out_ready = 1'b1;
    end

    always @(negedge clk) begin
        if (mon_en && sym_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", int'(sym_out), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(sym_out == e.sym && quad_i == e.qi && quad_q == e.qq, e.tag,
                    int'({quad_i, quad_q, sym_out}), int'({e.qi, e.qq, e.sym}));
            end
        end
    end

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_valid == 1'b0, "R6", int'(sym_valid), 0);
        chk(in_ready == 1'b1, "R7", int'(in_ready), 1);
        mon_en = 1'b1;
        @(posedge clk);
        #1;

        // R1: bytes before any frame start use width 8, variant A
        cur_tag = "R1";
        send(8'hA5, 1'b0);
        send(8'h3C, 1'b0);
        // R1: every width code, plus an out-of-range code
        for (int c = 0; c < 5; c++) begin
            qam_sel = 3'(c);
            send(8'($urandom), 1'b1);
            for (int n = 0; n < 11; n++) send(8'($urandom), 1'b0);
        end
        qam_sel = 3'd6;
        send(8'h96, 1'b1);
        for (int n = 0; n < 5; n++) send(8'($urandom), 1'b0);

        // R2: fixed patterns across byte joins at width 6
        cur_tag = "R2";
        qam_sel = 3'd2;
        send(8'hFF, 1'b1);
        send(8'h00, 1'b0);
        send(8'hAA, 1'b0);
        send(8'h55, 1'b0);
        send(8'h0F, 1'b0);
        send(8'hF0, 1'b0);

        // R4: repeated frames whose first symbol has unequal top bits
        cur_tag = "R4";
        for (int f = 0; f < 3; f++) begin
            send(8'h40, 1'b1);
            send(8'h40, 1'b0);
            send(8'h40, 1'b0);
        end

        // R3: variant C at every width under random stall
        cur_tag = "R3";
        annex_c = 1'b1;
        stall_mode = 1;
        for (int c = 0; c < 5; c++) begin
            qam_sel = 3'(c);
            send(8'($urandom), 1'b1);
            for (int n = 0; n < 14; n++) send(8'($urandom), 1'b0);
        end

        // R6: variant A under random stall
        cur_tag = "R6";
        annex_c = 1'b0;
        for (int c = 1; c < 4; c++) begin
            qam_sel = 3'(c);
            send(8'($urandom), 1'b1);
            for (int n = 0; n < 10; n++) send(8'($urandom), 1'b0);
        end

        // R5: back-to-back frame starts with changing width and variant
        cur_tag = "R5";
        for (int k = 0; k < 15; k++) begin
            qam_sel = 3'(k % 5);
            annex_c = 1'(k % 2);
            send(8'($urandom), 1'b1);
            for (int n = 0; n < k % 3; n++) send(8'($urandom), 1'b0);
        end
        stall_mode = 0;

        // R8: mode inputs changed mid-frame are ignored
        cur_tag = "R8";
        qam_sel = 3'd1;
        annex_c = 1'b0;
        send(8'hC3, 1'b1);
        send(8'h5A, 1'b0);
        qam_sel = 3'd4;
        annex_c = 1'b1;
        for (int n = 0; n < 6; n++) send(8'($urandom), 1'b0);

        // R7 / R6: forced stall with a symbol waiting
        idle(30);
        stall_mode = 2;
        idle(2);
        cur_tag = "R7";
        qam_sel = 3'd4;
        annex_c = 1'b0;
        send(8'h3C, 1'b1);
        send(8'h81, 1'b0);
        in_valid = 1'b1;
        in_data  = 8'h7E;
        in_sof   = 1'b0;
        @(negedge clk);
        held = sym_out;
        chk(sym_valid == 1'b1, "R6", int'(sym_valid), 1);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
        chk(sym_out == held, "R6", int'(sym_out), int'(held));
        @(posedge clk);
        #1;
        stall_mode = 0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        ref_push(8'h7E, 1'b0);
        @(posedge clk);
        #1;
        in_valid = 1'b0;

        // R9: drain and confirm nothing is missing
        for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(posedge clk);
        idle(5);
        chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule